// File: doc/BRIEF.md
# Streaming Gain and Offset Corrector

This block corrects a stream of digitizer samples with a digital gain and an offset, then clamps the result to the converter's code range. Each input sample is a 16-bit two's complement word. It carries a 10-bit conversion in its top bits, so its six low bits are zero. Two sets of correction terms are held in registers: a calibration pair and a user pair. A bypass flag selects between two modes. In calibrated mode both pairs apply. In bypass mode only the user pair applies, so the calibration terms have no effect.

Gains are unsigned Q6.10 numbers, so 1024 means a gain of one. Each product is rounded to nearest before any offset is subtracted. The final value is put back onto the 10-bit grid and clamped. Any clamp, whether at an intermediate product or at the output, sets a sticky overflow flag. Software clears that flag with a single-cycle pulse. Samples enter on a valid strobe and leave exactly three clock cycles later. A configuration write changes only the samples that enter after it.

Top module: `goc_corrector`

## Requirements
- R1: After reset, out_valid_o, out_data_o and ovf_o are 0. The active configuration is then the CAL_GAIN_RST and CAL_OFF_RST parameters, user gain 1024, user offset 0 and bypass off.
- R2: When the bypass flag is 0, the output is round(round(raw*cal_gain/1024)*usr_gain/1024) - cal_off - usr_off, followed by the requantisation of R5 and the limits of R6.
- R3: When the bypass flag is 1, the output is round(raw*usr_gain/1024) - usr_off. The calibration gain and offset have no effect. With a user gain of 1024 and a user offset of 0, an on-grid raw code comes out unchanged.
- R4: Each gain product is rounded to the nearest integer, with an exact half rounding toward positive infinity.
- R5: The output is always a multiple of 64. The pre-clamp value is rounded to the nearest multiple of 64, with a half step rounding toward positive infinity.
- R6: A result above 32704 outputs 32704 (0x7FC0). A result below -32768 outputs -32768 (0x8000). Either case sets the overflow flag.
- R7: An intermediate product outside [-32768, 32767] is clamped to that range before the next stage. This sets the overflow flag even if the final value is in range.
- R8: ovf_o is set when a flagged sample reaches the output. It stays set until an ovf_clr_i pulse. If a clear and a new flagged output fall on the same cycle, the flag stays set.
- R9: out_valid_o rises on the third rising edge after the edge that accepts a sample. Back-to-back samples come out back to back. out_data_o holds its value while out_valid_o is low.
- R10: A configuration write (cfg_we_i high) loads all five fields at once. A sample accepted on the same edge uses the old values. Samples accepted on later edges use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_cal_gain_i | input | 16 | Calibration gain, unsigned Q6.10 |
| cfg_cal_off_i | input | 16 | Calibration offset, signed |
| cfg_usr_gain_i | input | 16 | User gain, unsigned Q6.10 |
| cfg_usr_off_i | input | 16 | User offset, signed |
| cfg_bypass_i | input | 1 | 1 = ignore the calibration terms |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | 16 | Input sample, two's complement, MSB-aligned |
| ovf_clr_i | input | 1 | Clear pulse for the sticky overflow flag |
| out_valid_o | output | 1 | Output sample strobe |
| out_data_o | output | 16 | Corrected sample |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach from the ports is an intermediate clamp that the final value hides. Here the first product saturates, but a small user gain brings the result back inside the output range. The only visible trace is then the overflow flag. The stimulus reaches this with a large calibration gain applied to a large raw code, followed by a user gain of one half.

The bench also times a clear pulse to land on the same edge as a saturating output, to show that the set wins over the clear. It lines a configuration write up with a sample on the same edge to show which configuration that sample uses.

// File: rtl/goc_pkg.sv
`timescale 1ns/1ps
package goc_pkg;
  localparam int SAMPLE_W = 16;                       // sample word width
  localparam int GAIN_W   = 16;                       // gain width, unsigned
  localparam int FRAC_W   = 10;                       // fractional bits of gain
  localparam int GRID_LSB = 6;                        // zero LSBs of a 10-bit code
  localparam int OFFS_W   = SAMPLE_W + 1;             // width of summed offsets
  localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1 << FRAC_W);
endpackage

// File: rtl/goc_mul_round.sv
`timescale 1ns/1ps
module goc_mul_round #(
  parameter int DW   = 16,
  parameter int GW   = 16,
  parameter int FRAC = 10
) (
  input  logic signed [DW-1:0] a_i,
  input  logic        [GW-1:0] g_i,
  output logic signed [DW-1:0] y_o,
  output logic                 ovf_o
);
  localparam int PW = DW + GW + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);
  localparam logic signed [PW-1:0] YMAX = {{(GW+2){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] YMIN = {{(GW+2){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PW-1:0] prod, rnd;

  always_comb begin
    prod = $signed({{(GW+1){a_i[DW-1]}}, a_i}) * $signed({{(DW+1){1'b0}}, g_i});
    rnd  = (prod + HALF) >>> FRAC;  // round half up
    if (rnd > YMAX) begin
      y_o   = YMAX[DW-1:0];
      ovf_o = 1'b1;
    end else if (rnd < YMIN) begin
      y_o   = YMIN[DW-1:0];
      ovf_o = 1'b1;
    end else begin
      y_o   = rnd[DW-1:0];
      ovf_o = 1'b0;
    end
  end
endmodule

// File: rtl/goc_requant.sv
`timescale 1ns/1ps
module goc_requant #(
  parameter int DW  = 16,
  parameter int LSB = 6
) (
  input  logic signed [DW-1:0] p_i,
  input  logic signed [DW:0]   off_i,
  output logic        [DW-1:0] y_o,
  output logic                 sat_o
);
  localparam int SW = DW + 2;
  localparam logic signed [SW-1:0] HALF = SW'(2 ** (LSB - 1));
  localparam logic signed [SW-1:0] QMAX = SW'(2 ** (DW - 1 - LSB) - 1);
  localparam logic signed [SW-1:0] QMIN = -QMAX - SW'(1);

  logic signed [SW-1:0] diff, q;

  always_comb begin
    diff = $signed({{2{p_i[DW-1]}}, p_i}) - $signed({off_i[DW], off_i});
    q    = (diff + HALF) >>> LSB;
    if (q > QMAX) begin
      y_o   = {1'b0, {(DW-1-LSB){1'b1}}, {LSB{1'b0}}};
      sat_o = 1'b1;
    end else if (q < QMIN) begin
      y_o   = {1'b1, {(DW-1){1'b0}}};
      sat_o = 1'b1;
    end else begin
      y_o   = {q[DW-1-LSB:0], {LSB{1'b0}}};
      sat_o = 1'b0;
    end
  end
endmodule

// File: rtl/goc_corrector.sv
`timescale 1ns/1ps
module goc_corrector
  import goc_pkg::*;
#(
  parameter logic [GAIN_W-1:0]   CAL_GAIN_RST = GAIN_ONE,
  parameter logic [SAMPLE_W-1:0] CAL_OFF_RST  = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [GAIN_W-1:0]   cfg_cal_gain_i,
  input  logic [SAMPLE_W-1:0] cfg_cal_off_i,
  input  logic [GAIN_W-1:0]   cfg_usr_gain_i,
  input  logic [SAMPLE_W-1:0] cfg_usr_off_i,
  input  logic                cfg_bypass_i,
  input  logic                in_valid_i,
  input  logic [SAMPLE_W-1:0] in_data_i,
  input  logic                ovf_clr_i,
  output logic                out_valid_o,
  output logic [SAMPLE_W-1:0] out_data_o,
  output logic                ovf_o
);
  // configuration registers
  logic [GAIN_W-1:0]   cal_gain_q, usr_gain_q;
  logic [SAMPLE_W-1:0] cal_off_q, usr_off_q;
  logic                byp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_gain_q <= CAL_GAIN_RST;
      cal_off_q  <= CAL_OFF_RST;
      usr_gain_q <= GAIN_ONE;
      usr_off_q  <= '0;
      byp_q      <= 1'b0;
    end else if (cfg_we_i) begin
      cal_gain_q <= cfg_cal_gain_i;
      cal_off_q  <= cfg_cal_off_i;
      usr_gain_q <= cfg_usr_gain_i;
      usr_off_q  <= cfg_usr_off_i;
      byp_q      <= cfg_bypass_i;
    end
  end

  // stage 1: first product, config snapshot taken with the sample
  logic [GAIN_W-1:0]          g1_sel;
  logic signed [SAMPLE_W-1:0] p1_d;
  logic                       o1_d;
  logic signed [OFFS_W-1:0]   off_d;

  assign g1_sel = byp_q ? usr_gain_q : cal_gain_q;
  assign off_d  = byp_q ? $signed({usr_off_q[SAMPLE_W-1], usr_off_q})
                        : $signed({cal_off_q[SAMPLE_W-1], cal_off_q})
                        + $signed({usr_off_q[SAMPLE_W-1], usr_off_q});

  goc_mul_round #(.DW(SAMPLE_W), .GW(GAIN_W), .FRAC(FRAC_W)) u_mul1 (
    .a_i  ($signed(in_data_i)),
    .g_i  (g1_sel),
    .y_o  (p1_d),
    .ovf_o(o1_d)
  );

  logic                       v1_q, o1_q, byp1_q;
  logic signed [SAMPLE_W-1:0] p1_q;
  logic [GAIN_W-1:0]          ug1_q;
  logic signed [OFFS_W-1:0]   off1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      o1_q   <= 1'b0;
      byp1_q <= 1'b0;
      p1_q   <= '0;
      ug1_q  <= '0;
      off1_q <= '0;
    end else begin
      v1_q <= in_valid_i;
      if (in_valid_i) begin
        o1_q   <= o1_d;
        byp1_q <= byp_q;
        p1_q   <= p1_d;
        ug1_q  <= usr_gain_q;
        off1_q <= off_d;
      end
    end
  end

  // stage 2: user gain (calibrated mode only)
  logic signed [SAMPLE_W-1:0] p2_m;
  logic                       o2_m;

  goc_mul_round #(.DW(SAMPLE_W), .GW(GAIN_W), .FRAC(FRAC_W)) u_mul2 (
    .a_i  (p1_q),
    .g_i  (ug1_q),
    .y_o  (p2_m),
    .ovf_o(o2_m)
  );

  logic                       v2_q, o2_q;
  logic signed [SAMPLE_W-1:0] p2_q;
  logic signed [OFFS_W-1:0]   off2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2_q   <= 1'b0;
      o2_q   <= 1'b0;
      p2_q   <= '0;
      off2_q <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        o2_q   <= o1_q | (!byp1_q & o2_m);
        p2_q   <= byp1_q ? p1_q : p2_m;
        off2_q <= off1_q;
      end
    end
  end

  // stage 3: offset, requantise, clamp
  logic [SAMPLE_W-1:0] y3;
  logic                sat3;

  goc_requant #(.DW(SAMPLE_W), .LSB(GRID_LSB)) u_rq (
    .p_i  (p2_q),
    .off_i(off2_q),
    .y_o  (y3),
    .sat_o(sat3)
  );

  logic ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      ovf_q       <= 1'b0;
    end else begin
      out_valid_o <= v2_q;
      if (v2_q) out_data_o <= y3;
      // a new event wins over a clear
      ovf_q <= (ovf_q & !ovf_clr_i) | (v2_q & (sat3 | o2_q));
    end
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/goc_corrector_chk.sv
`timescale 1ns/1ps
module goc_corrector_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic [15:0] in_data_i,
  input logic        out_valid_o,
  input logic [15:0] out_data_o,
  input logic        ovf_o,
  input logic        ovf_clr_i,
  input logic        byp_q,
  input logic [15:0] usr_gain_q,
  input logic [15:0] usr_off_q
);
  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3) |-> (out_valid_o == $past(in_valid_i, 3))); // R9

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age != 2'd0 && !out_valid_o) |-> $stable(out_data_o)); // R9

  AST_ON_GRID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_data_o[5:0] == 6'd0)); // R5

  AST_BYPASS_UNITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3 && $past(in_valid_i && byp_q && usr_gain_q == 16'd1024 &&
                          usr_off_q == 16'd0 && in_data_i[5:0] == 6'd0, 3))
    |-> (out_data_o == $past(in_data_i, 3))); // R3

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o); // R8

  AST_OVF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_clr_i |=> (!ovf_o || out_valid_o)); // R8
endmodule

bind goc_corrector goc_corrector_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_data_i  (in_data_i),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o),
  .ovf_o      (ovf_o),
  .ovf_clr_i  (ovf_clr_i),
  .byp_q      (byp_q),
  .usr_gain_q (usr_gain_q),
  .usr_off_q  (usr_off_q)
);

// File: tb/goc_corrector_tb.sv
`timescale 1ns/1ps
module goc_corrector_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_byp = 1'b0, in_valid = 1'b0, ovf_clr = 1'b0;
  logic [15:0] cfg_cg = '0, cfg_co = '0, cfg_ug = '0, cfg_uo = '0, in_data = '0;
  logic out_valid, ovf;
  logic [15:0] out_data;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  goc_corrector #(.CAL_GAIN_RST(16'd2048), .CAL_OFF_RST(16'd64)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we),
    .cfg_cal_gain_i(cfg_cg), .cfg_cal_off_i(cfg_co),
    .cfg_usr_gain_i(cfg_ug), .cfg_usr_off_i(cfg_uo), .cfg_bypass_i(cfg_byp),
    .in_valid_i(in_valid), .in_data_i(in_data), .ovf_clr_i(ovf_clr),
    .out_valid_o(out_valid), .out_data_o(out_data), .ovf_o(ovf)
  );

  typedef struct packed {
    logic signed [15:0] raw;
    logic [15:0]        cg;
    logic signed [15:0] co;
    logic [15:0]        ug;
    logic signed [15:0] uo;
    logic               byp;
    logic signed [15:0] exp_d;
    logic               exp_o;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [0:NV-1] = '{
    '{ 16'sd6400,  16'd1024, 16'sd0,    16'd1024,  16'sd0,   1'b0,  16'sd6400,  1'b0}, // R2
    '{ 16'sd6400,  16'd2048, 16'sd64,   16'd1024,  16'sd0,   1'b0,  16'sd12736, 1'b0}, // R2
    '{-16'sd6400,  16'd1536, 16'sd0,    16'd512,   16'sd0,   1'b0, -16'sd4800,  1'b0}, // R2
    '{ 16'sd0,     16'd1024, -16'sd100, 16'd1024, -16'sd28,  1'b0,  16'sd128,   1'b0}, // R2
    '{ 16'sd0,     16'd1024, 16'sd100,  16'd1024,  16'sd60,  1'b0, -16'sd128,   1'b0}, // R5
    '{ 16'sd64,    16'd504,  16'sd0,    16'd1024,  16'sd0,   1'b0,  16'sd64,    1'b0}, // R4
    '{-16'sd32768, 16'd1024, 16'sd0,    16'd1024,  16'sd0,   1'b1, -16'sd32768, 1'b0}, // R3
    '{ 16'sd32704, 16'd4096, 16'sd5000, 16'd1024,  16'sd0,   1'b1,  16'sd32704, 1'b0}, // R3
    '{ 16'sd640,   16'd3000, 16'sd5000, 16'd1024,  16'sd64,  1'b1,  16'sd576,   1'b0}, // R3
    '{ 16'sd64,    16'd1024, 16'sd0,    16'd1536,  16'sd0,   1'b1,  16'sd128,   1'b0}, // R5
    '{-16'sd64,    16'd1024, 16'sd0,    16'd1536,  16'sd0,   1'b1, -16'sd64,    1'b0}, // R5
    '{ 16'sd19200, 16'd2048, 16'sd0,    16'd1024,  16'sd0,   1'b0,  16'sd32704, 1'b1}, // R6
    '{-16'sd19200, 16'd2048, 16'sd0,    16'd1024,  16'sd0,   1'b0, -16'sd32768, 1'b1}, // R7
    '{ 16'sd19200, 16'd2048, 16'sd0,    16'd512,   16'sd0,   1'b0,  16'sd16384, 1'b1}, // R7
    '{ 16'sd32704, 16'd1024, 16'sd0,    16'd1024, -16'sd64,  1'b1,  16'sd32704, 1'b1}, // R6
    '{-16'sd32768, 16'd1024, 16'sd0,    16'd1024,  16'sd64,  1'b1, -16'sd32768, 1'b1}  // R6
  };

  task automatic check(input string tag, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic set_cfg(input logic [15:0] cg, co, ug, uo, input logic byp);
    cfg_we = 1'b1; cfg_cg = cg; cfg_co = co; cfg_ug = ug; cfg_uo = uo; cfg_byp = byp;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 out_data", int'(out_data), 0);
    check("R1 ovf", int'(ovf), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 default config 2048/64, unity user, no bypass; R9 latency
    in_valid = 1'b1; in_data = 16'sd6400;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); check("R9 not yet valid", int'(out_valid), 0);
    @(negedge clk);
    check("R9 valid at 3rd edge", int'(out_valid), 1);
    check("R1 default cal", int'($signed(out_data)), 12736);

    // R9 back to back
    in_valid = 1'b1; in_data = 16'sd64;  @(negedge clk);
    in_data = 16'sd128; @(negedge clk);
    in_data = 16'sd192; @(negedge clk);
    in_valid = 1'b0;
    check("R9 b2b 0", int'($signed(out_data)), 64);
    @(negedge clk); check("R9 b2b 1", int'($signed(out_data)), 192);
    @(negedge clk); check("R9 b2b 2", int'($signed(out_data)), 320);
    check("R9 b2b valid", int'(out_valid), 1);
    @(negedge clk);
    check("R9 valid drop", int'(out_valid), 0);
    check("R9 data hold", int'($signed(out_data)), 320);

    // R10 write on same edge as a sample
    in_valid = 1'b1; in_data = 16'sd640;
    set_cfg(16'd2048, 16'd64, 16'd1024, 16'd0, 1'b1);
    @(negedge clk); cfg_we = 1'b0;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); check("R10 old cfg", int'($signed(out_data)), 1216);
    @(negedge clk); check("R10 new cfg", int'($signed(out_data)), 640);

    // vector table
    for (int i = 0; i < NV; i++) begin
      set_cfg(VECS[i].cg, VECS[i].co, VECS[i].ug, VECS[i].uo, VECS[i].byp);
      ovf_clr = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; ovf_clr = 1'b0;
      in_valid = 1'b1; in_data = VECS[i].raw;
      @(negedge clk); in_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check($sformatf("R2-table vec %0d data", i), int'($signed(out_data)), int'(VECS[i].exp_d));
      check($sformatf("R6/R7 vec %0d ovf", i), int'(ovf), int'(VECS[i].exp_o));
    end

    // R8 sticky: ovf set by last vector, clean sample keeps it
    in_valid = 1'b1; in_data = 16'sd0;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8 sticky hold", int'(ovf), 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    check("R8 cleared", int'(ovf), 0);
    // R8 clear and new event on the same edge
    in_valid = 1'b1; in_data = 16'h8000;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    check("R8 set wins over clear", int'(ovf), 1);

    done = 1'b1;
    summary();
  end
endmodule